// File: doc/BRIEF.md
# Hardware Push-Down Stack Controller

This block turns a plain synchronous single-port word memory into a hardware stack. It keeps the stack pointer in a register of its own and, for every accepted push or pop strobe, drives the memory port through two steps: a pointer update and a memory access. The stack occupies a window of addresses between a high base address and a low limit address and grows downward, so the first word pushed always lands at the base address.

A build-time parameter picks the pointer convention. In last-full mode the pointer names the word pushed most recently, so a push moves the pointer before writing and a pop reads before moving it. In next-empty mode the pointer names the free slot below the top, so a push writes before moving the pointer and a pop moves it before reading. The convention also fixes the pointer value that means "empty". Either way the data lands at the same physical addresses, so the two conventions differ only in timing and pointer values at the ports.

Requests are sampled only while the block is idle. A push on a full stack, or a pop on an empty one, does nothing but raise a one-cycle error pulse. Pop data comes straight from the memory read port, qualified by a valid pulse one cycle after the read address was driven.

Top module: `hw_stack_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, `stack_ptr` equals base+1 in last-full mode or base in next-empty mode, `empty` is 1, `full` is 0, `busy` is 0 and `pop_valid` is 0.
- R2: In last-full mode an accepted push decrements `stack_ptr` in the first busy cycle and writes `push_data` at the new pointer in the second busy cycle. The first push after reset therefore writes the base address.
- R3: In next-empty mode an accepted push writes `push_data` at the current pointer in the first busy cycle and decrements `stack_ptr` in the second busy cycle.
- R4: In last-full mode an accepted pop drives a read at the current pointer in the first busy cycle and increments the pointer in the second busy cycle. `pop_valid` is high in the cycle after the read, with `pop_data` carrying the word.
- R5: In next-empty mode an accepted pop increments the pointer in the first busy cycle and drives a read at the new pointer in the second busy cycle. `pop_valid` is high in the cycle after that read, which is the third cycle after the request was sampled.
- R6: Popped words come out in the reverse order of the pushes.
- R7: `empty` is 1 exactly when the stack holds no word. `full` is 1 exactly when every address from base down to limit (inclusive) holds a word. The two are never both 1.
- R8: A push while `full`, or a lone pop while `empty`, leaves the pointer and memory untouched, starts no busy period, and raises `req_err` for exactly the cycle after the request was sampled.
- R9: When push and pop are both requested in the same idle cycle, only the push is carried out (or rejected under R8), and no pop data is returned.
- R10: An accepted request holds `busy` high for exactly two cycles, starting the cycle after it was sampled. Requests seen while `busy` is high are ignored, and at most one of memory write and memory read is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Push request strobe, sampled when idle |
| pop_req | input | 1 | Pop request strobe, sampled when idle |
| push_data | input | DATA_W | Word to push, sampled with push_req |
| pop_data | output | DATA_W | Popped word, meaningful while pop_valid is high |
| pop_valid | output | 1 | One-cycle qualifier for pop_data |
| busy | output | 1 | An accepted request is in progress |
| full | output | 1 | Every slot in the stack window is used |
| empty | output | 1 | The stack holds no word |
| req_err | output | 1 | Pulse: the previous request was rejected |
| stack_ptr | output | ADDR_W | Current stack pointer value |
| mem_addr | output | ADDR_W | Memory address, equal to the stack pointer |
| mem_wr_en | output | 1 | Memory write enable |
| mem_wr_data | output | DATA_W | Memory write data |
| mem_rd_en | output | 1 | Memory read enable, data returned next cycle |
| mem_rd_data | input | DATA_W | Memory read data |

## Verification
Both conventions are built side by side and fed the same request stream. Any difference in write cycle, read cycle, valid cycle or pointer value between the two therefore shows up against a mode-specific expectation, while the popped data must agree. The stream mixes push-only runs that fill the window exactly to its limit, pops interleaved with pushes so that ordering errors change the data, combined push-and-pop strobes both below and at the limit, and over- and underflow attempts at both ends. A request raised during a busy period, and a reset taken with words on the stack, separate correct request gating and pointer restore from designs that leak state across either.

// File: rtl/hw_stack_pkg.sv
package hw_stack_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STEP1 = 2'd1,
        ST_STEP2 = 2'd2
    } stk_state_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } stk_op_e;

    typedef enum logic [2:0] {
        ACT_NONE  = 3'd0,
        ACT_DEC   = 3'd1,
        ACT_INC   = 3'd2,
        ACT_WRITE = 3'd3,
        ACT_READ  = 3'd4
    } stk_act_e;

    // Ordering of pointer move against memory access for each convention.
    function automatic stk_act_e step_action(stk_op_e op, logic last_full, stk_state_e st);
        stk_act_e act;
        act = ACT_NONE;
        if (st == ST_STEP1 || st == ST_STEP2) begin
            unique case (op)
                OP_PUSH: begin
                    if (last_full) act = (st == ST_STEP1) ? ACT_DEC   : ACT_WRITE;
                    else           act = (st == ST_STEP1) ? ACT_WRITE : ACT_DEC;
                end
                OP_POP: begin
                    if (last_full) act = (st == ST_STEP1) ? ACT_READ  : ACT_INC;
                    else           act = (st == ST_STEP1) ? ACT_INC   : ACT_READ;
                end
                default: act = ACT_NONE;
            endcase
        end
        return act;
    endfunction

endpackage

// File: rtl/hw_stack_ptr.sv
module hw_stack_ptr #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] RESET_PTR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    input  logic              dec,
    output logic [ADDR_W-1:0] ptr
);
    logic [ADDR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= RESET_PTR;
        end else if (dec) begin
            ptr_q <= ptr_q - 1'b1;
        end else if (inc) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/hw_stack_flags.sv
module hw_stack_flags #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] EMPTY_PTR = '0,
    parameter logic [ADDR_W-1:0] FULL_PTR  = '0
) (
    input  logic [ADDR_W-1:0] ptr,
    output logic              empty,
    output logic              full
);
    assign empty = (ptr == EMPTY_PTR);
    assign full  = (ptr == FULL_PTR);
endmodule

// File: rtl/hw_stack_seq.sv
module hw_stack_seq
    import hw_stack_pkg::*;
#(
    parameter bit LAST_FULL = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push_req,
    input  logic     pop_req,
    input  logic     empty,
    input  logic     full,
    output logic     accept_push,
    output logic     busy,
    output logic     req_err,
    output stk_act_e act
);
    stk_state_e state_q;
    stk_op_e    op_q;
    logic       err_q;
    logic       idle;
    logic       accept_pop;
    logic       reject;

    always_comb begin
        idle        = (state_q == ST_IDLE);
        accept_push = idle && push_req && !full;
        accept_pop  = idle && !push_req && pop_req && !empty;
        reject      = idle && ((push_req && full) || (!push_req && pop_req && empty));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_NONE;
            err_q   <= 1'b0;
        end else begin
            err_q <= reject;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept_push) begin
                        op_q    <= OP_PUSH;
                        state_q <= ST_STEP1;
                    end else if (accept_pop) begin
                        op_q    <= OP_POP;
                        state_q <= ST_STEP1;
                    end
                end
                ST_STEP1: state_q <= ST_STEP2;
                default: begin
                    state_q <= ST_IDLE;
                    op_q    <= OP_NONE;
                end
            endcase
        end
    end

    assign busy    = !idle;
    assign req_err = err_q;
    assign act     = step_action(op_q, LAST_FULL, state_q);
endmodule

// File: rtl/hw_stack_ctrl.sv
module hw_stack_ctrl
    import hw_stack_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 8'h13,
    parameter logic [ADDR_W-1:0] LIMIT_ADDR = 8'h10,
    parameter bit                LAST_FULL  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_valid,
    output logic              busy,
    output logic              full,
    output logic              empty,
    output logic              req_err,
    output logic [ADDR_W-1:0] stack_ptr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr_en,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              mem_rd_en,
    input  logic [DATA_W-1:0] mem_rd_data
);
    // Empty and full pointer values depend on what the pointer names.
    localparam logic [ADDR_W-1:0] EMPTY_PTR =
        LAST_FULL ? ADDR_W'(BASE_ADDR + 1'b1) : BASE_ADDR;
    localparam logic [ADDR_W-1:0] FULL_PTR =
        LAST_FULL ? LIMIT_ADDR : ADDR_W'(LIMIT_ADDR - 1'b1);

    stk_act_e          act;
    logic              accept_push;
    logic [DATA_W-1:0] data_q;
    logic              rd_pend_q;

    hw_stack_seq #(.LAST_FULL(LAST_FULL)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .push_req   (push_req),
        .pop_req    (pop_req),
        .empty      (empty),
        .full       (full),
        .accept_push(accept_push),
        .busy       (busy),
        .req_err    (req_err),
        .act        (act)
    );

    hw_stack_ptr #(.ADDR_W(ADDR_W), .RESET_PTR(EMPTY_PTR)) ptr_i (
        .clk(clk),
        .rst(rst),
        .inc(act == ACT_INC),
        .dec(act == ACT_DEC),
        .ptr(stack_ptr)
    );

    hw_stack_flags #(.ADDR_W(ADDR_W), .EMPTY_PTR(EMPTY_PTR), .FULL_PTR(FULL_PTR)) flags_i (
        .ptr  (stack_ptr),
        .empty(empty),
        .full (full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q    <= '0;
            rd_pend_q <= 1'b0;
        end else begin
            if (accept_push) data_q <= push_data;
            rd_pend_q <= (act == ACT_READ);
        end
    end

    assign mem_addr    = stack_ptr;
    assign mem_wr_en   = (act == ACT_WRITE);
    assign mem_wr_data = data_q;
    assign mem_rd_en   = (act == ACT_READ);
    assign pop_valid   = rd_pend_q;
    assign pop_data    = mem_rd_data;
endmodule

// File: rtl/hw_stack_ctrl_chk.sv
module hw_stack_ctrl_chk #(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 8'h13,
    parameter logic [ADDR_W-1:0] LIMIT_ADDR = 8'h10,
    parameter bit                LAST_FULL  = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              full,
    input logic              empty,
    input logic              req_err,
    input logic              pop_valid,
    input logic [ADDR_W-1:0] stack_ptr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_wr_en,
    input logic              mem_rd_en
);
    localparam logic [ADDR_W-1:0] HI_PTR =
        LAST_FULL ? ADDR_W'(BASE_ADDR + 1'b1) : BASE_ADDR;
    localparam logic [ADDR_W-1:0] LO_PTR =
        LAST_FULL ? LIMIT_ADDR : ADDR_W'(LIMIT_ADDR - 1'b1);

    AST_ONE_MEM_ACCESS: assert property (@(posedge clk) disable iff (rst)
        !(mem_wr_en && mem_rd_en)); // R10
    AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> pop_valid); // R4
    AST_VALID_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
        pop_valid |-> $past(mem_rd_en)); // R5
    AST_PTR_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (stack_ptr <= HI_PTR) && (stack_ptr >= LO_PTR)); // R7
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(full && empty)); // R7
    AST_WRITE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (mem_addr <= BASE_ADDR) && (mem_addr >= LIMIT_ADDR)); // R2
    AST_REJECT_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
        req_err |-> !busy); // R8
    AST_BUSY_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy); // R10
    AST_PTR_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> $stable(stack_ptr)); // R10
endmodule

bind hw_stack_ctrl hw_stack_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .LIMIT_ADDR(LIMIT_ADDR),
    .LAST_FULL (LAST_FULL)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .full     (full),
    .empty    (empty),
    .req_err  (req_err),
    .pop_valid(pop_valid),
    .stack_ptr(stack_ptr),
    .mem_addr (mem_addr),
    .mem_wr_en(mem_wr_en),
    .mem_rd_en(mem_rd_en)
);

// File: tb/hw_stack_ctrl_tb.sv
module hw_stack_ctrl_tb_top;
    // Index 0: last-full instance, index 1: next-empty instance.
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic push_req = 1'b0;
    logic pop_req = 1'b0;
    logic [15:0] push_data = '0;

    logic [1:0][15:0] pd, wd, rd;
    logic [1:0][7:0]  sp, ma;
    logic [1:0] pv, bsy, ful, emp, err, we, re;

    logic [15:0] mem0 [256];
    logic [15:0] mem1 [256];

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    int          vcyc [2];
    logic [15:0] vdat [2];
    logic        verr [2];
    logic        vbusy[2];
    int          wcyc [2];
    logic [7:0]  waddr[2];
    int          rcyc [2];
    logic [7:0]  raddr[2];

    always #2 clk = ~clk;

    hw_stack_ctrl #(.LAST_FULL(1'b1)) dut_i (
        .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
        .push_data(push_data), .pop_data(pd[0]), .pop_valid(pv[0]),
        .busy(bsy[0]), .full(ful[0]), .empty(emp[0]), .req_err(err[0]),
        .stack_ptr(sp[0]), .mem_addr(ma[0]), .mem_wr_en(we[0]),
        .mem_wr_data(wd[0]), .mem_rd_en(re[0]), .mem_rd_data(rd[0])
    );

    hw_stack_ctrl #(.LAST_FULL(1'b0)) dut_ne_i (
        .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
        .push_data(push_data), .pop_data(pd[1]), .pop_valid(pv[1]),
        .busy(bsy[1]), .full(ful[1]), .empty(emp[1]), .req_err(err[1]),
        .stack_ptr(sp[1]), .mem_addr(ma[1]), .mem_wr_en(we[1]),
        .mem_wr_data(wd[1]), .mem_rd_en(re[1]), .mem_rd_data(rd[1])
    );

    always_ff @(posedge clk) begin
        if (we[0]) mem0[ma[0]] <= wd[0];
        if (re[0]) rd[0] <= mem0[ma[0]];
        if (we[1]) mem1[ma[1]] <= wd[1];
        if (re[1]) rd[1] <= mem1[ma[1]];
    end

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_fail++;
            $display("FAIL R10 watchdog: actual %0d cycles expected under 50000", cyc);
            report();
            $finish;
        end
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // kind: 1 push, 2 pop, 3 push and pop together
    task automatic run_op(input int kind, input logic [15:0] d);
        for (int m = 0; m < 2; m++) begin
            vcyc[m] = 0; wcyc[m] = 0; rcyc[m] = 0;
            vdat[m] = '0; waddr[m] = '0; raddr[m] = '0;
        end
        @(negedge clk);
        push_req  = kind[0];
        pop_req   = kind[1];
        push_data = d;
        @(negedge clk);
        push_req = 1'b0;
        pop_req  = 1'b0;
        for (int c = 1; c <= 4; c++) begin
            for (int m = 0; m < 2; m++) begin
                if (c == 1) begin verr[m] = err[m]; vbusy[m] = bsy[m]; end
                if (pv[m] && vcyc[m] == 0) begin vcyc[m] = c; vdat[m] = pd[m]; end
                if (we[m] && wcyc[m] == 0) begin wcyc[m] = c; waddr[m] = ma[m]; end
                if (re[m] && rcyc[m] == 0) begin rcyc[m] = c; raddr[m] = ma[m]; end
            end
            if (c < 4) @(negedge clk);
        end
    endtask

    task automatic check_reset_state();
        check_eq("R1", "lf ptr", int'(sp[0]), 8'h14);
        check_eq("R1", "ne ptr", int'(sp[1]), 8'h13);
        for (int m = 0; m < 2; m++) begin
            check_eq("R1", "empty", int'(emp[m]), 1);
            check_eq("R1", "full", int'(ful[m]), 0);
            check_eq("R1", "busy", int'(bsy[m]), 0);
            check_eq("R1", "pop_valid", int'(pv[m]), 0);
        end
    endtask

    // {kind[2], push data[16], expected pop data[16], expected error[1], depth after[4]}
    localparam int NVEC = 16;
    localparam logic [38:0] VEC [NVEC] = '{
        {2'd2, 16'h0000, 16'h0000, 1'b1, 4'd0},
        {2'd1, 16'h00A1, 16'h0000, 1'b0, 4'd1},
        {2'd1, 16'h00B2, 16'h0000, 1'b0, 4'd2},
        {2'd2, 16'h0000, 16'h00B2, 1'b0, 4'd1},
        {2'd1, 16'h00C3, 16'h0000, 1'b0, 4'd2},
        {2'd1, 16'h00D4, 16'h0000, 1'b0, 4'd3},
        {2'd1, 16'h00E5, 16'h0000, 1'b0, 4'd4},
        {2'd1, 16'h0077, 16'h0000, 1'b1, 4'd4},
        {2'd3, 16'h0088, 16'h0000, 1'b1, 4'd4},
        {2'd2, 16'h0000, 16'h00E5, 1'b0, 4'd3},
        {2'd3, 16'h0099, 16'h0000, 1'b0, 4'd4},
        {2'd2, 16'h0000, 16'h0099, 1'b0, 4'd3},
        {2'd2, 16'h0000, 16'h00D4, 1'b0, 4'd2},
        {2'd2, 16'h0000, 16'h00C3, 1'b0, 4'd1},
        {2'd2, 16'h0000, 16'h00A1, 1'b0, 4'd0},
        {2'd2, 16'h0000, 16'h0000, 1'b1, 4'd0}
    };

    initial begin
        int pv_seen;
        repeat (3) @(negedge clk);
        check_reset_state();                         // R1 during reset
        rst = 1'b0;
        @(negedge clk);
        check_reset_state();                         // R1 after reset

        for (int i = 0; i < NVEC; i++) begin
            int          kind;
            logic [15:0] d, ed;
            logic        ee;
            int          dep;
            kind = int'(VEC[i][38:37]);
            d    = VEC[i][36:21];
            ed   = VEC[i][20:5];
            ee   = VEC[i][4];
            dep  = int'(VEC[i][3:0]);
            run_op(kind, d);
            for (int m = 0; m < 2; m++) begin
                string tag_mode, tag_pop;
                tag_mode = (m == 0) ? "R2" : "R3";
                tag_pop  = (m == 0) ? "R4" : "R5";
                check_eq("R8", "req_err", int'(verr[m]), int'(ee));
                check_eq(tag_mode, "ptr", int'(sp[m]), (m == 0) ? 8'h14 - dep : 8'h13 - dep);
                check_eq("R7", "empty", int'(emp[m]), int'(dep == 0));
                check_eq("R7", "full", int'(ful[m]), int'(dep == 4));
                if (ee) begin
                    check_eq("R8", "no access", wcyc[m] + rcyc[m] + vcyc[m], 0);
                    check_eq("R10", "busy on reject", int'(vbusy[m]), 0);
                end else begin
                    check_eq("R10", "busy", int'(vbusy[m]), 1);
                    if (kind != 2) begin
                        check_eq(tag_mode, "write cycle", wcyc[m], (m == 0) ? 2 : 1);
                        check_eq(tag_mode, "write addr", int'(waddr[m]), 8'h14 - dep);
                        check_eq("R9", "no pop data", vcyc[m] + rcyc[m], 0);
                    end else begin
                        check_eq(tag_pop, "read cycle", rcyc[m], (m == 0) ? 1 : 2);
                        check_eq(tag_pop, "read addr", int'(raddr[m]), 8'h13 - dep);
                        check_eq(tag_pop, "valid cycle", vcyc[m], (m == 0) ? 2 : 3);
                        check_eq("R6", "pop data", int'(vdat[m]), int'(ed));
                    end
                end
            end
        end

        // R10: a pop raised during the busy period of a push is ignored.
        @(negedge clk);
        push_req = 1'b1; push_data = 16'h005A;
        @(negedge clk);
        push_req = 1'b0; pop_req = 1'b1;
        pv_seen = 0;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            pop_req = 1'b0;
            pv_seen += int'(pv[0]) + int'(pv[1]);
        end
        check_eq("R10", "no pop while busy", pv_seen, 0);
        check_eq("R10", "lf ptr after", int'(sp[0]), 8'h13);
        check_eq("R10", "ne ptr after", int'(sp[1]), 8'h12);
        run_op(2, 16'h0);
        for (int m = 0; m < 2; m++) begin
            check_eq("R6", "pushed word survives", int'(vdat[m]), 16'h005A);
            check_eq("R7", "empty again", int'(emp[m]), 1);
        end

        // R1: reset with words on the stack restores the empty pointer.
        run_op(1, 16'h0011);
        run_op(1, 16'h0022);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_reset_state();
        run_op(2, 16'h0);
        for (int m = 0; m < 2; m++) begin
            check_eq("R8", "pop after reset rejected", int'(verr[m]), 1);
        end

        report();
        $finish;
    end
endmodule